// File: doc/BRIEF.md
# Sync-Reset Video Timing Counter

This block sets the pixel and line timing for an image sensor front end. A pixel counter runs up to a programmed last-pixel index and then wraps. Each wrap advances a line counter, which wraps at a programmed last-line index. A one-clock HD pulse marks pixel 0 of every line. A one-clock VD pulse marks pixel 0 of line 0. A free-running phase counter drives a bundle of generic sensor clock outputs.

An external SYNC pin realigns the timing. The pin is first corrected for polarity, so that the internal level is low while SYNC is active. It then passes through two flops, and the second flop is the state register of the control FSM. The FSM has three states:

- `ST_RUN`: normal timing.
- `ST_HOLD`: SYNC is active in normal mode. The counters are frozen at zero. The clock bundle is parked at the hold levels when suspend was set.
- `ST_RESYNC`: SYNC is active in mode 2. The counters are cleared on entry and then keep running. VD may be gated. The clock bundle is always parked.

The FSM has four transitions:

- `RUN->HOLD`: SYNC asserts while mode 2 is off.
- `RUN->RESYNC`: SYNC asserts while mode 2 is on.
- `HOLD->RUN`: SYNC releases.
- `RESYNC->RUN`: SYNC releases.

Each transition back to `ST_RUN` restarts the counters from zero and steps a 2-bit field designator.

Top module: `frame_sync_timer`

## Requirements
- R1: While reset is applied, the field designator is 0, the counters are zero, and the phase counter is zero. HD and VD therefore read 1 and the clock bundle reads 0.
- R2: In `ST_RUN`, HD is high for exactly one clock out of every `cfg_line_last`+1 clocks. This holds for `cfg_line_last` of 1 or more.
- R3: VD is high only together with HD, on line 0. In `ST_RUN` this happens once every (`cfg_frame_last`+1) lines.
- R4: The internal SYNC level is `sync_pin` XOR `cfg_sync_inv`. SYNC is active when this level is 0.
- R5: A change on `sync_pin` changes the FSM state at the second rising clock edge after the change.
- R6: In `ST_HOLD`, both counters are held at zero and HD and VD stay low.
- R7: In the first cycle of `ST_RUN` after a release, HD and VD are both high, because the counters restart from zero.
- R8: The field designator increments by one on each release and wraps from 3 to 0. It changes at no other time.
- R9: The clock bundle normally shows bits [NCLK-1:0] of a phase counter that increments every clock and is never cleared by SYNC. In `ST_HOLD` it shows `cfg_hold_level` if `cfg_suspend` was 1 when the state was entered.
- R10: On entry to `ST_RESYNC`, the counters clear to zero, so HD is high in the first `ST_RESYNC` cycle. After that they count normally.
- R11: In `ST_RESYNC`, VD is forced low if `cfg_vd_gate` was 1 at entry. If it was 0, VD pulses as in `ST_RUN`.
- R12: In `ST_RESYNC`, the clock bundle equals `cfg_hold_level` whatever the value of `cfg_suspend`.
- R13: Changes to `cfg_suspend`, `cfg_mode2` and `cfg_vd_gate` made while SYNC is active have no effect until the next entry from `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin | input | 1 | External SYNC pin |
| cfg_sync_inv | input | 1 | 1 inverts the pin before use |
| cfg_suspend | input | 1 | Park the clock bundle during SYNC in normal mode |
| cfg_mode2 | input | 1 | Select mode 2 (resync on assert, counters keep running) |
| cfg_vd_gate | input | 1 | Gate VD during SYNC in mode 2 |
| cfg_hold_level | input | NCLK | Parked levels of the clock bundle |
| cfg_line_last | input | PIX_W | Last pixel index of a line |
| cfg_frame_last | input | LINE_W | Last line index of a frame |
| hd_o | output | 1 | Line-start pulse |
| vd_o | output | 1 | Frame-start pulse |
| field_o | output | FLD_W | Field designator |
| clk_o | output | NCLK | Generic sensor clock bundle |

## Verification
In mode 2, the counter clear on entering `ST_RESYNC` can land in the same cycle as a natural pixel or frame wrap. A suspend, mode or gate change can also land in the same cycle as the edge that latches it. The bench times several SYNC episodes so that assertion and release fall at different phases of the line and frame counters. It also toggles the configuration inputs while SYNC is held. A cycle-level reference model, written from the requirements, predicts HD, VD, the field and the clock bundle for every clock. A monitor judges each cycle against that prediction, for example that a clear coinciding with a wrap yields a single HD and not two.

// File: rtl/fst_pkg.sv
package fst_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RESYNC = 2'd2
    } fst_state_e;
endpackage

// File: rtl/fst_sync_in.sv
// Polarity correction and first synchronizer stage; the control FSM's
// state register acts as the second stage.
module fst_sync_in (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic inv,
    output logic level_s1
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_s1 <= 1'b1;        // inactive after reset
        else        level_s1 <= pin ^ inv;
    end
endmodule

// File: rtl/fst_timebase.sv
// Pixel/line counters with synchronous clear, plus a free-running phase.
module fst_timebase #(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11,
    parameter int NCLK   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PIX_W-1:0]  line_last,
    input  logic [LINE_W-1:0] frame_last,
    output logic              pix_zero,
    output logic              line_zero,
    output logic [NCLK-1:0]   phase
);
    logic [PIX_W-1:0]  pix_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q  <= '0;
            line_q <= '0;
        end else if (clr) begin
            pix_q  <= '0;
            line_q <= '0;
        end else if (pix_q == line_last) begin
            pix_q  <= '0;
            line_q <= (line_q == frame_last) ? '0 : line_q + 1'b1;
        end else begin
            pix_q  <= pix_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    assign pix_zero  = (pix_q == '0);
    assign line_zero = (line_q == '0);
endmodule

// File: rtl/fst_ctrl.sv
// SYNC control FSM: state register, latched episode options, field
// designator and output decode.
module fst_ctrl
    import fst_pkg::*;
#(
    parameter int NCLK  = 8,
    parameter int FLD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_lvl,
    input  logic             cfg_suspend,
    input  logic             cfg_mode2,
    input  logic             cfg_vd_gate,
    input  logic [NCLK-1:0]  cfg_hold_level,
    input  logic             pix_zero,
    input  logic             line_zero,
    input  logic [NCLK-1:0]  phase,
    output logic             clr,
    output fst_state_e       state,
    output logic             hd,
    output logic             vd,
    output logic [FLD_W-1:0] field,
    output logic [NCLK-1:0]  clk_out
);
    fst_state_e state_q, state_d;
    logic       susp_q, gate_q;
    logic       held;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:            if (!sync_lvl) state_d = cfg_mode2 ? ST_RESYNC : ST_HOLD;
            ST_HOLD, ST_RESYNC: if (sync_lvl) state_d = ST_RUN;
            default:           state_d = ST_RUN;
        endcase
    end

    // State register (second synchronizer stage), options and field.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            susp_q  <= 1'b0;
            gate_q  <= 1'b0;
            field   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) begin
                susp_q <= cfg_suspend;
                gate_q <= cfg_vd_gate;
            end
            if (state_q != ST_RUN && state_d == ST_RUN)
                field <= field + 1'b1;
        end
    end

    assign clr   = (state_d != state_q) || (state_d == ST_HOLD);
    assign state = state_q;

    // Output decode.
    always_comb begin
        hd      = pix_zero && (state_q != ST_HOLD);
        vd      = hd && line_zero && !(state_q == ST_RESYNC && gate_q);
        held    = (state_q == ST_HOLD && susp_q) || (state_q == ST_RESYNC);
        clk_out = held ? cfg_hold_level : phase;
    end
endmodule

// File: rtl/frame_sync_timer.sv
module frame_sync_timer
    import fst_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11,
    parameter int NCLK   = 8,
    parameter int FLD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_pin,
    input  logic              cfg_sync_inv,
    input  logic              cfg_suspend,
    input  logic              cfg_mode2,
    input  logic              cfg_vd_gate,
    input  logic [NCLK-1:0]   cfg_hold_level,
    input  logic [PIX_W-1:0]  cfg_line_last,
    input  logic [LINE_W-1:0] cfg_frame_last,
    output logic              hd_o,
    output logic              vd_o,
    output logic [FLD_W-1:0]  field_o,
    output logic [NCLK-1:0]   clk_o
);
    logic            sync_s1, clr, pix_zero, line_zero;
    logic [NCLK-1:0] phase;
    fst_state_e      st;

    fst_sync_in u_sync (
        .clk(clk), .rst_n(rst_n), .pin(sync_pin), .inv(cfg_sync_inv),
        .level_s1(sync_s1)
    );

    fst_timebase #(.PIX_W(PIX_W), .LINE_W(LINE_W), .NCLK(NCLK)) u_tb (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .line_last(cfg_line_last), .frame_last(cfg_frame_last),
        .pix_zero(pix_zero), .line_zero(line_zero), .phase(phase)
    );

    fst_ctrl #(.NCLK(NCLK), .FLD_W(FLD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sync_lvl(sync_s1),
        .cfg_suspend(cfg_suspend), .cfg_mode2(cfg_mode2),
        .cfg_vd_gate(cfg_vd_gate), .cfg_hold_level(cfg_hold_level),
        .pix_zero(pix_zero), .line_zero(line_zero), .phase(phase),
        .clr(clr), .state(st), .hd(hd_o), .vd(vd_o),
        .field(field_o), .clk_out(clk_o)
    );
endmodule

// File: rtl/fst_checker.sv
module fst_checker
    import fst_pkg::*;
#(
    parameter int NCLK  = 8,
    parameter int FLD_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hd_o,
    input logic             vd_o,
    input logic [FLD_W-1:0] field_o,
    input logic [NCLK-1:0]  clk_o,
    input logic [NCLK-1:0]  cfg_hold_level,
    input fst_state_e       st
);
    localparam logic [FLD_W-1:0] FLD_ONE = 1;

    // R2: a line pulse lasts one clock unless the state changes under it
    p_hd_one_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hd_o |=> (!hd_o || st != $past(st)));

    // R3
    p_vd_with_hd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vd_o |-> hd_o);

    // R6
    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (!hd_o && !vd_o));

    // R7
    p_release_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) != ST_RUN) |-> (hd_o && vd_o));

    // R8
    p_field_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (field_o != $past(field_o)) |-> (field_o == $past(field_o) + FLD_ONE));

    // R8: the field only moves on a release
    p_field_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (field_o != $past(field_o)) |-> (st == ST_RUN && $past(st) != ST_RUN));

    // R12
    p_resync_parked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESYNC) |-> (clk_o == cfg_hold_level));
endmodule

bind frame_sync_timer fst_checker #(.NCLK(NCLK), .FLD_W(FLD_W)) u_fst_chk (
    .clk(clk), .rst_n(rst_n), .hd_o(hd_o), .vd_o(vd_o), .field_o(field_o),
    .clk_o(clk_o), .cfg_hold_level(cfg_hold_level), .st(st)
);

// File: tb/test_frame_sync_timer.sv
module test_frame_sync_timer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LL = 9;
    localparam int  FL = 3;
    localparam logic [7:0] HOLD = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_pin = 1'b1, cfg_sync_inv = 1'b0;
    logic        cfg_suspend = 1'b0, cfg_mode2 = 1'b0, cfg_vd_gate = 1'b0;
    logic [7:0]  cfg_hold_level = HOLD;
    logic [11:0] cfg_line_last = 12'(LL);
    logic [10:0] cfg_frame_last = 11'(FL);
    logic        hd_o, vd_o;
    logic [1:0]  field_o;
    logic [7:0]  clk_o;

    int unsigned n_checks = 0, n_errors = 0;

    frame_sync_timer i_frame_sync_timer (
        .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .cfg_sync_inv(cfg_sync_inv),
        .cfg_suspend(cfg_suspend), .cfg_mode2(cfg_mode2), .cfg_vd_gate(cfg_vd_gate),
        .cfg_hold_level(cfg_hold_level), .cfg_line_last(cfg_line_last),
        .cfg_frame_last(cfg_frame_last), .hd_o(hd_o), .vd_o(vd_o),
        .field_o(field_o), .clk_o(clk_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic       hd, vd;
        logic [1:0] fld;
        logic [7:0] ck;
        string      thd, tvd, tck;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model, advanced at each rising edge (0 run, 1 hold, 2 resync).
    int       m_st = 0, m_pix = 0, m_line = 0;
    bit       m_s1 = 1'b1, m_susp = 1'b0, m_gate = 1'b0;
    bit [1:0] m_fld = 0;
    bit [7:0] m_ph = 0;

    always @(posedge clk) begin
        exp_t e;
        int   nst;
        if (!rst_n) begin
            m_st = 0; m_s1 = 1'b1; m_pix = 0; m_line = 0;
            m_fld = 0; m_ph = 0; m_susp = 1'b0; m_gate = 1'b0;
        end else begin
            nst = m_st;
            if (m_st == 0 && !m_s1) nst = cfg_mode2 ? 2 : 1;
            else if (m_st != 0 && m_s1) begin nst = 0; m_fld = m_fld + 2'd1; end
            if (m_st == 0) begin m_susp = cfg_suspend; m_gate = cfg_vd_gate; end
            if (nst != m_st || nst == 1) begin m_pix = 0; m_line = 0; end
            else if (m_pix == LL) begin
                m_pix = 0;
                m_line = (m_line == FL) ? 0 : m_line + 1;
            end else m_pix = m_pix + 1;
            m_st = nst;
            m_s1 = sync_pin ^ cfg_sync_inv;
            m_ph = m_ph + 8'd1;
        end
        e.hd  = (m_st != 1) && (m_pix == 0);
        e.vd  = e.hd && (m_line == 0) && !(m_st == 2 && m_gate);
        e.fld = m_fld;
        e.ck  = ((m_st == 1 && m_susp) || m_st == 2) ? HOLD : m_ph;
        e.thd = (m_st == 1) ? "R6" : (m_st == 2) ? "R10" : "R2";
        e.tvd = (m_st == 2) ? "R11" : "R3";
        e.tck = (m_st == 2) ? "R12" : "R9";
        exp_q.push_back(e);
    end

    // Monitor: compare one expected item per clock, away from the edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(hd_o === e.hd, e.thd, "hd", int'(hd_o), int'(e.hd));
            chk(vd_o === e.vd, e.tvd, "vd", int'(vd_o), int'(e.vd));
            chk(field_o === e.fld, "R8", "field", int'(field_o), int'(e.fld));
            chk(clk_o === e.ck, e.tck, "clk bundle", int'(clk_o), int'(e.ck));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        chk(field_o == 2'd0, "R1", "reset field", int'(field_o), 0);
        chk(hd_o && vd_o, "R1", "reset hd&vd", int'({hd_o, vd_o}), 3);
        chk(clk_o == 8'd0, "R1", "reset clk bundle", int'(clk_o), 0);
        rst_n = 1'b1;
        cyc(100);

        // Episode 1: normal mode with suspend; suspend dropped mid-episode
        cfg_suspend = 1'b1;
        sync_pin = 1'b0;
        cyc(2);
        chk(hd_o == 1'b0, "R5", "hd two edges after assert", int'(hd_o), 0);
        chk(clk_o == HOLD, "R5", "bundle parked after two edges", int'(clk_o), int'(HOLD));
        cyc(5);
        cfg_suspend = 1'b0;
        cyc(5);
        chk(clk_o == HOLD, "R13", "suspend change ignored", int'(clk_o), int'(HOLD));
        cyc(20);
        sync_pin = 1'b1;
        cyc(2);
        chk(hd_o && vd_o, "R7", "restart pulses", int'({hd_o, vd_o}), 3);
        chk(field_o == 2'd1, "R8", "field after release 1", int'(field_o), 1);

        // Episode 2: normal mode, no suspend
        cyc(57);
        sync_pin = 1'b0;
        cyc(25);
        sync_pin = 1'b1;
        cyc(2);
        chk(field_o == 2'd2, "R8", "field after release 2", int'(field_o), 2);

        // Episode 3: inverted polarity
        cyc(33);
        cfg_sync_inv = 1'b1;
        sync_pin = 1'b0;
        cyc(20);
        sync_pin = 1'b1;
        cyc(2);
        chk(hd_o == 1'b0, "R4", "inverted pin high is active", int'(hd_o), 0);
        cyc(10);
        sync_pin = 1'b0;
        cyc(2);
        chk(field_o == 2'd3, "R8", "field after release 3", int'(field_o), 3);

        // Episode 4: mode 2 with VD gate; mode dropped mid-episode
        cyc(41);
        cfg_sync_inv = 1'b0;
        sync_pin = 1'b1;
        cfg_mode2 = 1'b1;
        cfg_vd_gate = 1'b1;
        cyc(1);
        sync_pin = 1'b0;
        cyc(2);
        chk(hd_o == 1'b1, "R10", "entry clears counters", int'(hd_o), 1);
        chk(vd_o == 1'b0, "R11", "vd gated at entry", int'(vd_o), 0);
        cyc(10);
        cfg_mode2 = 1'b0;
        cyc(50);
        sync_pin = 1'b1;
        cyc(2);
        chk(field_o == 2'd0, "R8", "field wraps to 0", int'(field_o), 0);

        // Episode 5: mode 2 without gate, spanning frames
        cfg_mode2 = 1'b1;
        cfg_vd_gate = 1'b0;
        cyc(17);
        sync_pin = 1'b0;
        cyc(70);
        sync_pin = 1'b1;
        cyc(30);

        finish_run();
    end
endmodule